// File: doc/BRIEF.md
# Branch Resolve and Flush Control

This block owns the program counter of a five-stage pipeline and the fetch-to-decode register. It decides in the decode stage whether a control instruction changes the flow, and it repairs the fetch stream when the guess made at fetch time was wrong. Fetch looks up a 16-entry table of one-bit last-outcome predictors, addressed by the low word-address bits of the fetch PC. For a conditional branch whose entry says "taken" it fetches the branch target next. Otherwise it fetches the next sequential word.

When the control instruction sits in decode, the block compares its operands for equality, computes the real target and checks the real next PC against the PC that was actually fetched behind it. On a mismatch it loads the correct PC and replaces the decode-stage instruction with a no-operation, so a wrong guess costs one slot. A correct guess costs nothing. The predictor entry of a conditional branch is then rewritten with the real outcome. A build parameter selects an architectural delay-slot mode. In that mode fetch never guesses, the word after a branch always proceeds, and a taken branch only steers the PC that comes after it.

A stall request from the hazard unit freezes the PC and the decode register. A branch that is stalled in decode is not resolved until the stall drops.

Top module: `branch_resolve_unit`

## Requirements
- R1: After reset the fetch PC equals the reset address (default 0), the decode register holds no valid instruction, and every predictor entry reads not-taken.
- R2: Without stall or squash, the PC advances by 4 each cycle unless a guess or redirect applies, and the decode register captures the fetched word and its PC in the next cycle with the valid flag set.
- R3: Opcode field bits [31:26] select the kind: 0x04 branches when the operands are equal, 0x05 branches when they differ, and 0x02 is an unconditional jump. The branch target is the decode PC + 4 + (sign-extended bits [15:0] shifted left by 2). The jump target is {upper 4 bits of decode PC + 4, bits [25:0], 2'b00}. A redirect loads this target into the fetch PC on the next edge.
- R4: When the real next PC of a resolving control instruction differs from the PC fetched behind it, squash is asserted, and on the next edge the decode register holds the no-operation word 0 with its valid flag clear for exactly one slot.
- R5: When the guess matches the real outcome, neither redirect nor squash is asserted and no cycle is lost.
- R6: The predictor is indexed by PC[5:2]. When a conditional branch resolves, its entry is written with the real outcome. At fetch, a conditional branch whose entry is set is predicted taken and its target is fetched next.
- R7: Jumps are not predicted at fetch, so in normal mode each jump whose target is not PC+4 causes a redirect and squash. Jumps do not write the predictor.
- R8: While the stall input is high, the fetch PC and the decode register hold. A control instruction in decode is not resolved (no redirect, no squash, no predictor write) until the first cycle the stall is low.
- R9: In delay-slot mode fetch never guesses taken. The word after a branch always enters decode and is never squashed. A taken branch asserts redirect and the fetch PC moves to the target after the slot.
- R10: Squash is only asserted while decode holds a valid instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchInstr | input | XLEN | Word read from instruction memory at fetchPc |
| stallReq | input | 1 | Hazard-unit request to hold the decode instruction |
| regA | input | XLEN | First operand of the decode instruction |
| regB | input | XLEN | Second operand of the decode instruction |
| fetchPc | output | XLEN | Address presented to instruction memory |
| idInstr | output | XLEN | Instruction held in the decode register |
| idPc | output | XLEN | PC of the decode instruction |
| idValid | output | 1 | Decode register holds a real instruction |
| redirect | output | 1 | PC is being loaded with a resolved address this cycle |
| squash | output | 1 | Decode register is cleared to a no-operation at the next edge |

## Verification
A stall request and the resolution of a branch in decode can fall in the same cycle. The bench holds a taken branch in decode for two cycles with the stall high. It expects no redirect or squash and frozen fetch and decode PCs during those cycles. It then expects the redirect to the branch target in the first unstalled cycle. A second overlap is the squash and the predictor write on one edge. It is judged by driving a loop branch through its first, middle and exit iterations and checking the squash flag and the next fetch address on each visit.

// File: rtl/bru_pkg.sv
`timescale 1ns/1ps
package bru_pkg;
  localparam logic [5:0] OP_BR_EQ = 6'h04;
  localparam logic [5:0] OP_BR_NE = 6'h05;
  localparam logic [5:0] OP_JUMP  = 6'h02;

  // Strobes from control to datapath
  typedef struct packed {
    logic hold;       // freeze PC and decode register
    logic redirect;   // load resolved next PC
    logic squash;     // turn decode register into a bubble
    logic useTarget;  // resolved next PC is the target
    logic train;      // write predictor entry
    logic trainVal;   // outcome to write
  } bruStrobe_t;

  // Status from datapath to control
  typedef struct packed {
    logic [5:0] op;
    logic       valid;
    logic       opsEqual;
    logic       targetMatches;
    logic       seqMatches;
  } bruFlags_t;
endpackage

// File: rtl/bru_predictor.sv
`timescale 1ns/1ps
module bru_predictor #(
  parameter int IDX_BITS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [IDX_BITS-1:0] rdIdx,
  output logic                rdBit,
  input  logic                wrEn,
  input  logic [IDX_BITS-1:0] wrIdx,
  input  logic                wrVal
);
  localparam int ENTRIES = 1 << IDX_BITS;

  logic [ENTRIES-1:0] lastTaken;

  always_ff @(posedge clk) begin
    if (!rstN) lastTaken <= '0;
    else if (wrEn) lastTaken[wrIdx] <= wrVal;
  end

  assign rdBit = lastTaken[rdIdx];
endmodule

// File: rtl/bru_datapath.sv
`timescale 1ns/1ps
module bru_datapath
  import bru_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          IDX_BITS   = 4,
  parameter logic [31:0] RESET_PC   = 32'h0,
  parameter bit          DELAY_SLOT = 1'b0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [XLEN-1:0]     fetchInstr,
  input  logic [XLEN-1:0]     regA,
  input  logic [XLEN-1:0]     regB,
  input  bruStrobe_t          strobe,
  output bruFlags_t           flags,
  output logic [IDX_BITS-1:0] predIdx,
  input  logic                predBit,
  output logic [IDX_BITS-1:0] trainIdx,
  output logic [XLEN-1:0]     fetchPc,
  output logic [XLEN-1:0]     idInstr,
  output logic [XLEN-1:0]     idPc,
  output logic                idValid
);
  localparam int          EXT_BITS = XLEN - 18;
  localparam logic [XLEN-1:0] WORD = XLEN'(4);

  logic [XLEN-1:0] pcQ, idInstrQ, idPcQ, idNextQ;
  logic            idValidQ;

  // Fetch side: sequential address and guessed target
  logic [XLEN-1:0] pcPlus4, fOffset, fTarget, fNext;
  logic            fIsCond, fGuess;

  assign pcPlus4 = pcQ + WORD;
  assign fOffset = {{EXT_BITS{fetchInstr[15]}}, fetchInstr[15:0], 2'b00};
  assign fTarget = pcPlus4 + fOffset;
  assign fIsCond = (fetchInstr[31:26] == OP_BR_EQ) || (fetchInstr[31:26] == OP_BR_NE);
  assign predIdx = pcQ[IDX_BITS+1:2];

  generate
    if (DELAY_SLOT) begin : g_noGuess
      assign fGuess = 1'b0;
    end else begin : g_guess
      assign fGuess = fIsCond & predBit;
    end
  endgenerate

  assign fNext = fGuess ? fTarget : pcPlus4;

  // Decode side: real target, comparator, match checks
  logic [XLEN-1:0] idPlus4, dOffset, brTarget, jmpTarget, dTarget, resolvedPc;

  assign idPlus4   = idPcQ + WORD;
  assign dOffset   = {{EXT_BITS{idInstrQ[15]}}, idInstrQ[15:0], 2'b00};
  assign brTarget  = idPlus4 + dOffset;
  assign jmpTarget = {idPlus4[XLEN-1:28], idInstrQ[25:0], 2'b00};
  assign dTarget   = (idInstrQ[31:26] == OP_JUMP) ? jmpTarget : brTarget;
  assign resolvedPc = strobe.useTarget ? dTarget : idPlus4;

  assign flags.op            = idInstrQ[31:26];
  assign flags.valid         = idValidQ;
  assign flags.opsEqual      = (regA == regB);
  assign flags.targetMatches = (dTarget == idNextQ);
  assign flags.seqMatches    = (idPlus4 == idNextQ);
  assign trainIdx            = idPcQ[IDX_BITS+1:2];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ      <= XLEN'(RESET_PC);
      idInstrQ <= '0;
      idPcQ    <= '0;
      idNextQ  <= '0;
      idValidQ <= 1'b0;
    end else if (!strobe.hold) begin
      pcQ <= strobe.redirect ? resolvedPc : fNext;
      if (strobe.squash) begin
        idInstrQ <= '0;
        idValidQ <= 1'b0;
        idPcQ    <= pcQ;
        idNextQ  <= fNext;
      end else begin
        idInstrQ <= fetchInstr;
        idValidQ <= 1'b1;
        idPcQ    <= pcQ;
        idNextQ  <= fNext;
      end
    end
  end

  assign fetchPc = pcQ;
  assign idInstr = idInstrQ;
  assign idPc    = idPcQ;
  assign idValid = idValidQ;
endmodule

// File: rtl/bru_control.sv
`timescale 1ns/1ps
module bru_control
  import bru_pkg::*;
#(
  parameter bit DELAY_SLOT = 1'b0
) (
  input  bruFlags_t  flags,
  input  logic       stallReq,
  output bruStrobe_t strobe
);
  logic isCond, isJump, isCtl, taken, resolve, guessOk;

  assign isCond  = (flags.op == OP_BR_EQ) || (flags.op == OP_BR_NE);
  assign isJump  = (flags.op == OP_JUMP);
  assign isCtl   = flags.valid & (isCond | isJump);
  assign taken   = isJump
                 | ((flags.op == OP_BR_EQ) &  flags.opsEqual)
                 | ((flags.op == OP_BR_NE) & ~flags.opsEqual);
  assign resolve = isCtl & ~stallReq;
  assign guessOk = taken ? flags.targetMatches : flags.seqMatches;

  generate
    if (DELAY_SLOT) begin : g_slot
      assign strobe.redirect = resolve & taken;
      assign strobe.squash   = 1'b0;
    end else begin : g_spec
      assign strobe.redirect = resolve & ~guessOk;
      assign strobe.squash   = resolve & ~guessOk;
    end
  endgenerate

  assign strobe.hold      = stallReq;
  assign strobe.useTarget = taken;
  assign strobe.train     = resolve & isCond;
  assign strobe.trainVal  = taken;
endmodule

// File: rtl/branch_resolve_unit.sv
`timescale 1ns/1ps
module branch_resolve_unit
  import bru_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          IDX_BITS   = 4,
  parameter logic [31:0] RESET_PC   = 32'h0,
  parameter bit          DELAY_SLOT = 1'b0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [XLEN-1:0] fetchInstr,
  input  logic            stallReq,
  input  logic [XLEN-1:0] regA,
  input  logic [XLEN-1:0] regB,
  output logic [XLEN-1:0] fetchPc,
  output logic [XLEN-1:0] idInstr,
  output logic [XLEN-1:0] idPc,
  output logic            idValid,
  output logic            redirect,
  output logic            squash
);
  bruStrobe_t          strobe;
  bruFlags_t           flags;
  logic [IDX_BITS-1:0] predIdx, trainIdx;
  logic                predBit;

  bru_predictor #(.IDX_BITS(IDX_BITS)) u_pred (
    .clk(clk), .rstN(rstN),
    .rdIdx(predIdx), .rdBit(predBit),
    .wrEn(strobe.train), .wrIdx(trainIdx), .wrVal(strobe.trainVal)
  );

  bru_datapath #(
    .XLEN(XLEN), .IDX_BITS(IDX_BITS), .RESET_PC(RESET_PC), .DELAY_SLOT(DELAY_SLOT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .fetchInstr(fetchInstr), .regA(regA), .regB(regB),
    .strobe(strobe), .flags(flags), .predIdx(predIdx), .predBit(predBit),
    .trainIdx(trainIdx), .fetchPc(fetchPc), .idInstr(idInstr), .idPc(idPc),
    .idValid(idValid)
  );

  bru_control #(.DELAY_SLOT(DELAY_SLOT)) u_ctl (
    .flags(flags), .stallReq(stallReq), .strobe(strobe)
  );

  assign redirect = strobe.redirect;
  assign squash   = strobe.squash;
endmodule

// File: rtl/bru_checker.sv
`timescale 1ns/1ps
module bru_checker #(
  parameter int XLEN       = 32,
  parameter bit DELAY_SLOT = 1'b0
) (
  input logic            clk,
  input logic            rstN,
  input logic            stallReq,
  input logic [XLEN-1:0] fetchPc,
  input logic [XLEN-1:0] idInstr,
  input logic [XLEN-1:0] idPc,
  input logic            idValid,
  input logic            redirect,
  input logic            squash
);
  p_flow_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!stallReq && !squash) |=> (idValid && idPc == $past(fetchPc)));

  p_squash_bubble_r4: assert property (@(posedge clk) disable iff (!rstN)
    squash |=> (!idValid && idInstr == '0));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    stallReq |=> ($stable(fetchPc) && $stable(idPc) && $stable(idValid)));

  p_stall_no_resolve_r8: assert property (@(posedge clk) disable iff (!rstN)
    stallReq |-> (!redirect && !squash));

  p_slot_kept_r9: assert property (@(posedge clk) disable iff (!rstN)
    (DELAY_SLOT == 1'b0) || !squash);

  p_squash_valid_r10: assert property (@(posedge clk) disable iff (!rstN)
    squash |-> (idValid && redirect));
endmodule

bind branch_resolve_unit bru_checker #(.XLEN(XLEN), .DELAY_SLOT(DELAY_SLOT)) u_chk (
  .clk(clk), .rstN(rstN), .stallReq(stallReq), .fetchPc(fetchPc),
  .idInstr(idInstr), .idPc(idPc), .idValid(idValid),
  .redirect(redirect), .squash(squash)
);

// File: tb/tb_branch_resolve_unit.sv
`timescale 1ns/1ps
module tb_branch_resolve_unit;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  int nChk = 0;
  int nFail = 0;

  // Program: 0x10 bne -> 0x08, 0x20 beq -> 0x00, 0x30 jump -> 0x40, 0x48 beq -> 0x50
  function automatic logic [31:0] progWord(input logic [31:0] a);
    case (a)
      32'h10:  return 32'h1422FFFD;
      32'h20:  return 32'h1022FFF7;
      32'h30:  return 32'h08000010;
      32'h48:  return 32'h10220001;
      default: return 32'h0;
    endcase
  endfunction

  logic rstN = 1'b0, dsRstN = 1'b0, stallReq = 1'b0;
  logic [31:0] regA = '0, regB = '0, dsRegA = '0, dsRegB = '0;
  logic [31:0] fetchPc, idInstr, idPc, dsFetchPc, dsIdInstr, dsIdPc;
  logic idValid, redirect, squash, dsIdValid, dsRedirect, dsSquash;

  branch_resolve_unit dut (
    .clk(clk), .rstN(rstN), .fetchInstr(progWord(fetchPc)), .stallReq(stallReq),
    .regA(regA), .regB(regB), .fetchPc(fetchPc), .idInstr(idInstr), .idPc(idPc),
    .idValid(idValid), .redirect(redirect), .squash(squash)
  );

  branch_resolve_unit #(.DELAY_SLOT(1'b1)) dutDs (
    .clk(clk), .rstN(dsRstN), .fetchInstr(progWord(dsFetchPc)), .stallReq(1'b0),
    .regA(dsRegA), .regB(dsRegB), .fetchPc(dsFetchPc), .idInstr(dsIdInstr), .idPc(dsIdPc),
    .idValid(dsIdValid), .redirect(dsRedirect), .squash(dsSquash)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    regA = '0; regB = '0; dsRegA = '0; dsRegB = '0;
    #1;
  endtask

  task automatic runUntil(input logic [31:0] t);
    for (int i = 0; i < 200; i++) begin
      step();
      if (idValid && idPc == t) return;
    end
    chk("R2 reach pc", idPc, t);
  endtask

  task automatic runUntilDs(input logic [31:0] t);
    for (int i = 0; i < 200; i++) begin
      step();
      if (dsIdValid && dsIdPc == t) return;
    end
    chk("R9 reach pc", dsIdPc, t);
  endtask

  // {taken, expected squash, expected fetchPc after the edge}
  localparam logic [33:0] LOOP_VEC [0:4] = '{
    {1'b1, 1'b1, 32'h08},   // first iteration: entry reads not-taken
    {1'b1, 1'b0, 32'h0C},
    {1'b1, 1'b0, 32'h0C},
    {1'b1, 1'b0, 32'h0C},
    {1'b0, 1'b1, 32'h14}    // exit: entry reads taken
  };

  initial begin
    #(20 * 50000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset pc", fetchPc, 32'h0);
    chk("R1 reset valid", {31'b0, idValid}, 32'h0);
    @(negedge clk); rstN = 1'b1;
    step();
    chk("R2 pc advance", fetchPc, 32'h4);
    chk("R2 id pc", idPc, 32'h0);
    chk("R2 id valid", {31'b0, idValid}, 32'h1);

    // Loop branch: first and exit visits mispredict, middle ones hit
    for (int v = 0; v < 5; v++) begin
      runUntil(32'h10);
      regA = 32'h0;
      regB = LOOP_VEC[v][33] ? 32'h1 : 32'h0;
      #1;
      if (v > 0 && v < 4) chk("R6 guessed target fetched", fetchPc, 32'h08);
      chk(LOOP_VEC[v][32] ? "R4 loop mispredict squash" : "R5 loop hit no squash",
          {31'b0, squash}, {31'b0, LOOP_VEC[v][32]});
      step();
      chk("R3 next fetch pc", fetchPc, LOOP_VEC[v][31:0]);
      if (LOOP_VEC[v][32]) begin
        chk("R4 bubble valid", {31'b0, idValid}, 32'h0);
        chk("R4 bubble word", idInstr, 32'h0);
        chk("R10 no squash on bubble", {31'b0, squash}, 32'h0);
      end
    end

    // Not-taken beq with not-taken entry: correct guess
    runUntil(32'h20);
    regA = 32'h0; regB = 32'h1; #1;
    chk("R5 not-taken hit squash", {31'b0, squash}, 32'h0);
    chk("R5 not-taken hit redirect", {31'b0, redirect}, 32'h0);
    step();
    chk("R5 sequential continues", fetchPc, 32'h28);

    // Jump always resolved in decode
    runUntil(32'h30);
    chk("R7 jump squash", {31'b0, squash}, 32'h1);
    step();
    chk("R7 R3 jump target", fetchPc, 32'h40);

    // Stall overlapping a taken branch in decode
    runUntil(32'h48);
    stallReq = 1'b1; #1;
    chk("R8 stall blocks redirect", {30'b0, redirect, squash}, 32'h0);
    step();
    chk("R8 stall holds pc", fetchPc, 32'h4C);
    chk("R8 stall holds id", idPc, 32'h48);
    step();
    chk("R8 stall holds pc again", fetchPc, 32'h4C);
    @(negedge clk);
    stallReq = 1'b0; regA = '0; regB = '0; #1;
    chk("R8 resolves after stall", {31'b0, squash}, 32'h1);
    step();
    chk("R8 R3 forward target", fetchPc, 32'h50);

    // Delay-slot instance
    @(negedge clk); dsRstN = 1'b1;
    runUntilDs(32'h10);
    dsRegA = 32'h0; dsRegB = 32'h1; #1;
    chk("R9 taken redirect", {31'b0, dsRedirect}, 32'h1);
    chk("R9 no squash", {31'b0, dsSquash}, 32'h0);
    step();
    chk("R9 slot enters decode", dsIdPc, 32'h14);
    chk("R9 slot valid", {31'b0, dsIdValid}, 32'h1);
    chk("R9 target after slot", dsFetchPc, 32'h08);
    runUntilDs(32'h10);
    chk("R9 no guess at fetch", dsFetchPc, 32'h14);
    dsRegA = 32'h5; dsRegB = 32'h5; #1;
    chk("R9 not-taken no redirect", {31'b0, dsRedirect}, 32'h0);
    step();
    chk("R9 sequential after slot", dsFetchPc, 32'h18);

    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule